// File: doc/BRIEF.md
# I2C Bit-Level Master Engine

This block carries out one bus primitive at a time on an open-drain two-wire bus. The primitives are a START (or a repeated START when a transfer is already open), a STOP, a byte write that samples the target's acknowledge, and a byte read that returns the commanded acknowledge. A controller above it formats addresses and sequences transfers. The engine is told which primitive to run and gets back a one-cycle completion pulse that carries a status code and, for reads, the received byte.

Both lines are driven only through pull-low enables: a 1 on `scl_pull` or `sda_pull` pulls that line low, and a 0 leaves it to the external pull-up. Each line's real level comes back through a synchronizer. The engine uses the returned levels to wait out clock stretching, with a fixed bound of 200 polls. It also uses them to detect another master winning arbitration. On lost arbitration it releases the bus, forgets the open transfer and pulses a recovery request to a bus-clear unit. Every timed interval is one programmable half-period, which lasts `half_period + 1` clock cycles. This covers bus rates from about 10 kbit/s to 1 Mbit/s.

The state machine has these states:
- `S_IDLE`: waits for a command.
- `S_RS_STR`: releases both lines and waits out clock stretching, as the first step of a repeated START.
- `S_RS_WAIT`: waits one half-period after that release.
- `S_ST_CHK`: checks that SDA is high before the START.
- `S_ST_HOLD`: holds SDA low for one half-period while SCL is released.
- `S_SP_LOW`: pulls both lines low for one half-period.
- `S_SP_STR`: releases SCL with SDA still low and waits out clock stretching.
- `S_SP_SETUP`: waits one half-period with SCL released and SDA low.
- `S_SP_BUF`: releases SDA and waits two half-periods before the SDA check.
- `S_WB_SETUP`, `S_WB_HIGH`, `S_WB_STR`: drive one bit out (set it up, release SCL, wait out stretching).
- `S_RB_SETUP`, `S_RB_STR`, `S_RB_HIGH`: sample one bit in (release SDA, release SCL and wait out stretching, sample at the end of the high half-period).

The transitions are:
- From `S_IDLE`, START goes to `S_RS_STR` if a transfer is open and to `S_ST_CHK` if not.
- START continues `S_RS_STR`→`S_RS_WAIT`→`S_ST_CHK`→`S_ST_HOLD`→`S_IDLE`.
- STOP runs `S_SP_LOW`→`S_SP_STR`→`S_SP_SETUP`→`S_SP_BUF`→`S_IDLE`.
- A write runs eight `S_WB_*` loops and then one `S_RB_*` loop for the acknowledge.
- A read runs eight `S_RB_*` loops and then one `S_WB_*` loop for the acknowledge.
- A stretch timeout, a lost arbitration or the end of a primitive returns to `S_IDLE`.

Top module: `i2cp_engine`

## Requirements
- R1: Lines are open-drain. `scl_pull`/`sda_pull` = 1 pulls the line low. In idle with no open transfer both are 0. In idle with a transfer open, SCL is pulled and SDA is released.
- R2: A START with no open transfer checks SDA high, then asserts `sda_pull` with `scl_pull` = 0 for exactly one half-period, then asserts `scl_pull`. It ends with status 0 (OK) and `bus_open` = 1.
- R3: A START that finds SDA low ends with status 2 (arbitration lost), a `recover_req` pulse, both lines released and `bus_open` = 0.
- R4: A START while `bus_open` = 1 first releases both lines, waits out stretching, waits one half-period, then runs the R2 sequence.
- R5: A write (command 2) sends `wr_byte` MSB first, one bit per SCL high. The ninth bit is sampled: low gives status 0, high gives status 1 (no acknowledge).
- R6: When a written data bit is 1 and SDA reads low while SCL is high, the write ends with status 2 and behaves as in R3.
- R7: A read (command 3) shifts SDA in MSB first, sampled at the end of each SCL high half-period, into `rd_byte`. The ninth bit pulls SDA low when `rd_ack` = 1 and releases it when `rd_ack` = 0.
- R8: After each SCL release the engine waits while SCL reads low. After 200 low polls it ends with status 3 (timeout), both lines released and `bus_open` = 0. A shorter stretch completes normally.
- R9: A STOP (command 1) pulls SDA low, releases SCL, releases SDA, clears `bus_open` and waits two half-periods. It then ends with status 0, or with status 2 if SDA reads low.
- R10: `done` is high for exactly one cycle per command. `cmd_valid` is ignored while `busy` = 1.
- R11: Every half-period wait lasts `half_period + 1` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_period | input | 12 | Half-period length minus one, in clock cycles |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd | input | 2 | 0 START, 1 STOP, 2 write byte, 3 read byte |
| wr_byte | input | 8 | Byte to write |
| rd_ack | input | 1 | 1 = acknowledge the read byte |
| busy | output | 1 | A primitive is running |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 OK, 1 no acknowledge, 2 arbitration lost, 3 timeout |
| rd_byte | output | 8 | Byte received by the last read |
| bus_open | output | 1 | A START was issued and no STOP or abort followed |
| recover_req | output | 1 | Pulse asking for bus-clear after lost arbitration |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 pulls SDA low |
| scl_in | input | 1 | SCL level read from the pin |
| sda_in | input | 1 | SDA level read from the pin |

## Verification
The assertions assume that `cmd` is meaningful only in a cycle where `cmd_valid` is high. They also assume that the line inputs behave as a wired-AND of the engine's pulls and the other devices' pulls. The bench keeps both conditions by building `scl_in` and `sda_in` from `scl_pull`/`sda_pull` together with a modelled target that only ever pulls low. It changes the target's pulls only while SCL is low, or deliberately when it models stretching, a stuck SDA or a competing master.

// File: rtl/i2cp_pkg.sv
package i2cp_pkg;
    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        RS_OK   = 2'd0,
        RS_NACK = 2'd1,
        RS_ARB  = 2'd2,
        RS_TMO  = 2'd3
    } res_e;

    typedef enum logic [3:0] {
        S_IDLE, S_RS_STR, S_RS_WAIT, S_ST_CHK, S_ST_HOLD,
        S_SP_LOW, S_SP_STR, S_SP_SETUP, S_SP_BUF,
        S_WB_SETUP, S_WB_HIGH, S_WB_STR,
        S_RB_SETUP, S_RB_STR, S_RB_HIGH
    } state_e;
endpackage

// File: rtl/i2cp_sync.sv
module i2cp_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] d,
    output logic [LINES-1:0] q
);
    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic [STAGES-1:0] ff;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff <= '1;
            else        ff <= {ff[STAGES-2:0], d[i]};
        end
        assign q[i] = ff[STAGES-1];
    end
endmodule

// File: rtl/i2cp_tick.sv
module i2cp_tick #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         tick
);
    logic [W-1:0] cnt;

    assign tick = run && (cnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (!run || tick) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/i2cp_engine.sv
module i2cp_engine
    import i2cp_pkg::*;
#(
    parameter int HP_W        = 12,
    parameter int STRETCH_LIM = 200,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [HP_W-1:0] half_period,
    input  logic            cmd_valid,
    input  logic [1:0]      cmd,
    input  logic [7:0]      wr_byte,
    input  logic            rd_ack,
    output logic            busy,
    output logic            done,
    output logic [1:0]      status,
    output logic [7:0]      rd_byte,
    output logic            bus_open,
    output logic            recover_req,
    output logic            scl_pull,
    output logic            sda_pull,
    input  logic            scl_in,
    input  logic            sda_in
);
    localparam int SC_W = $clog2(STRETCH_LIM + 1);

    state_e      state_q, state_d;
    logic        scl_s, sda_s, hp_run, hp_tick, is_str, str_to;
    logic [SC_W-1:0] str_cnt;
    logic [7:0]  shift_q;
    logic [2:0]  bitcnt_q;
    logic        ack_phase_q, rdack_q, buf2_q, out_bit;
    op_e         op_q;
    logic        fin;
    res_e        fin_st;

    i2cp_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q({scl_s, sda_s})
    );

    i2cp_tick #(.W(HP_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(hp_run), .limit(half_period), .tick(hp_tick)
    );

    assign hp_run = state_q inside {S_RS_WAIT, S_ST_HOLD, S_SP_LOW, S_SP_SETUP, S_SP_BUF,
                                    S_WB_SETUP, S_WB_HIGH, S_RB_SETUP, S_RB_HIGH};
    assign is_str = state_q inside {S_RS_STR, S_SP_STR, S_WB_STR, S_RB_STR};
    assign str_to = is_str && !scl_s && (str_cnt == SC_W'(STRETCH_LIM - 1));
    assign out_bit = ack_phase_q ? ~rdack_q : shift_q[7];
    assign busy = (state_q != S_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        fin     = 1'b0;
        fin_st  = RS_OK;
        unique case (state_q)
            S_IDLE: if (cmd_valid) begin
                unique case (op_e'(cmd))
                    OP_START: state_d = bus_open ? S_RS_STR : S_ST_CHK;
                    OP_STOP:  state_d = S_SP_LOW;
                    OP_WRITE: state_d = S_WB_SETUP;
                    OP_READ:  state_d = S_RB_SETUP;
                    default:  state_d = S_IDLE;
                endcase
            end
            S_RS_STR:   if (str_to) begin fin = 1'b1; fin_st = RS_TMO; end
                        else if (scl_s) state_d = S_RS_WAIT;
            S_RS_WAIT:  if (hp_tick) state_d = S_ST_CHK;
            S_ST_CHK:   if (!sda_s) begin fin = 1'b1; fin_st = RS_ARB; end
                        else state_d = S_ST_HOLD;
            S_ST_HOLD:  if (hp_tick) fin = 1'b1;
            S_SP_LOW:   if (hp_tick) state_d = S_SP_STR;
            S_SP_STR:   if (str_to) begin fin = 1'b1; fin_st = RS_TMO; end
                        else if (scl_s) state_d = S_SP_SETUP;
            S_SP_SETUP: if (hp_tick) state_d = S_SP_BUF;
            S_SP_BUF:   if (hp_tick && buf2_q) begin
                            fin = 1'b1; fin_st = sda_s ? RS_OK : RS_ARB;
                        end
            S_WB_SETUP: if (hp_tick) state_d = S_WB_HIGH;
            S_WB_HIGH:  if (hp_tick) state_d = S_WB_STR;
            S_WB_STR:   if (str_to) begin fin = 1'b1; fin_st = RS_TMO; end
                        else if (scl_s) begin
                            if (!ack_phase_q && shift_q[7] && !sda_s) begin
                                fin = 1'b1; fin_st = RS_ARB;
                            end else if (ack_phase_q) fin = 1'b1;
                            else if (bitcnt_q == 3'd7) state_d = S_RB_SETUP;
                            else state_d = S_WB_SETUP;
                        end
            S_RB_SETUP: if (hp_tick) state_d = S_RB_STR;
            S_RB_STR:   if (str_to) begin fin = 1'b1; fin_st = RS_TMO; end
                        else if (scl_s) state_d = S_RB_HIGH;
            S_RB_HIGH:  if (hp_tick) begin
                            if (ack_phase_q) begin fin = 1'b1; fin_st = sda_s ? RS_NACK : RS_OK; end
                            else if (bitcnt_q == 3'd7) state_d = S_WB_SETUP;
                            else state_d = S_RB_SETUP;
                        end
            default:    state_d = S_IDLE;
        endcase
        if (fin) state_d = S_IDLE;
    end

    // line outputs
    always_comb begin
        scl_pull = 1'b0;
        sda_pull = 1'b0;
        unique case (state_q)
            S_IDLE:                          scl_pull = bus_open;
            S_ST_HOLD:                       sda_pull = 1'b1;
            S_SP_LOW:   begin scl_pull = 1'b1; sda_pull = 1'b1; end
            S_SP_STR, S_SP_SETUP:            sda_pull = 1'b1;
            S_WB_SETUP: begin scl_pull = 1'b1; sda_pull = ~out_bit; end
            S_WB_HIGH, S_WB_STR:             sda_pull = ~out_bit;
            S_RB_SETUP:                      scl_pull = 1'b1;
            default: ;
        endcase
    end

    // datapath and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q     <= '0;
            bitcnt_q    <= '0;
            ack_phase_q <= 1'b0;
            rdack_q     <= 1'b0;
            buf2_q      <= 1'b0;
            op_q        <= OP_START;
            str_cnt     <= '0;
            bus_open    <= 1'b0;
            done        <= 1'b0;
            status      <= RS_OK;
            recover_req <= 1'b0;
            rd_byte     <= '0;
        end else begin
            done        <= 1'b0;
            recover_req <= 1'b0;
            str_cnt     <= (is_str && !scl_s) ? str_cnt + 1'b1 : '0;
            if (state_q == S_IDLE && cmd_valid) begin
                shift_q     <= wr_byte;
                bitcnt_q    <= '0;
                ack_phase_q <= 1'b0;
                rdack_q     <= rd_ack;
                buf2_q      <= 1'b0;
                op_q        <= op_e'(cmd);
            end
            if (state_q == S_WB_STR && scl_s && !ack_phase_q) begin
                shift_q  <= {shift_q[6:0], 1'b0};
                bitcnt_q <= bitcnt_q + 1'b1;
                if (bitcnt_q == 3'd7) ack_phase_q <= 1'b1;
            end
            if (state_q == S_RB_HIGH && hp_tick && !ack_phase_q) begin
                shift_q  <= {shift_q[6:0], sda_s};
                bitcnt_q <= bitcnt_q + 1'b1;
                if (bitcnt_q == 3'd7) begin
                    ack_phase_q <= 1'b1;
                    rd_byte     <= {shift_q[6:0], sda_s};
                end
            end
            if (state_q == S_SP_SETUP && hp_tick) bus_open <= 1'b0;
            if (state_q == S_SP_BUF && hp_tick)   buf2_q   <= 1'b1;
            if (fin) begin
                done        <= 1'b1;
                status      <= fin_st;
                recover_req <= (fin_st == RS_ARB);
                if (fin_st == RS_ARB || fin_st == RS_TMO) bus_open <= 1'b0;
                else if (op_q == OP_START)                bus_open <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2cp_engine_chk.sv
module i2cp_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       busy,
    input logic       done,
    input logic [1:0] status,
    input logic       bus_open,
    input logic       recover_req,
    input logic       scl_pull,
    input logic       sda_pull
);
    assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !bus_open) |-> (!scl_pull && !sda_pull));

    assert_open_holds_scl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && bus_open) |-> (scl_pull && !sda_pull));

    assert_arb_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == 2'd2) |-> (!bus_open && recover_req));

    assert_recover_only_arb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        recover_req |-> (done && status == 2'd2));

    assert_timeout_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == 2'd3) |-> !bus_open);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> busy);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind i2cp_engine i2cp_engine_chk u_chk (.*);

// File: tb/test_i2cp_engine.sv
module test_i2cp_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] half_period = 12'd3;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd = 2'd0;
    logic [7:0]  wr_byte = 8'h00;
    logic        rd_ack = 1'b0;
    logic        busy, done, bus_open, recover_req, scl_pull, sda_pull;
    logic [1:0]  status;
    logic [7:0]  rd_byte;
    logic        scl_bus, sda_bus;

    // modelled target
    int          slv_mode = 0;   // 0 none, 1 ack, 2 send tx, 3 pull at bit0, 4 hold SDA low
    logic        slv_ack = 1'b1;
    logic [7:0]  slv_tx = 8'h00;
    logic        slv_scl_hold = 1'b0;
    logic        slv_sda_low;
    int          falls = 0;
    int          base = 0;
    int          idx;
    logic [7:0]  cap = 8'h00;
    logic        cap_ack = 1'b0;

    int          n_run = 0, n_fail = 0;
    int          hold_cnt = 0, rel_cnt = 0;
    logic [1:0]  r_st;
    logic [7:0]  r_rb;
    logic        r_rec;

    always #4 clk = ~clk;

    assign scl_bus = !(scl_pull || slv_scl_hold);
    assign sda_bus = !(sda_pull || slv_sda_low);
    assign idx = falls - base;

    always_comb begin
        unique case (slv_mode)
            1: slv_sda_low = (idx == 8) && slv_ack;
            2: slv_sda_low = (idx >= 0 && idx < 8) ? !slv_tx[7 - idx[2:0]] : 1'b0;
            3: slv_sda_low = (idx == 0);
            4: slv_sda_low = 1'b1;
            default: slv_sda_low = 1'b0;
        endcase
    end

    always @(negedge scl_bus) falls = falls + 1;
    always @(posedge scl_bus) begin
        if (idx >= 0 && idx < 8) cap = {cap[6:0], sda_bus};
        if (idx == 8) cap_ack = sda_bus;
    end
    always @(negedge clk) begin
        if (sda_pull && !scl_pull) hold_cnt = hold_cnt + 1;
        if (busy && !scl_pull && !sda_pull) rel_cnt = rel_cnt + 1;
    end

    i2cp_engine i_i2cp_engine (
        .clk(clk), .rst_n(rst_n), .half_period(half_period),
        .cmd_valid(cmd_valid), .cmd(cmd), .wr_byte(wr_byte), .rd_ack(rd_ack),
        .busy(busy), .done(done), .status(status), .rd_byte(rd_byte),
        .bus_open(bus_open), .recover_req(recover_req),
        .scl_pull(scl_pull), .sda_pull(sda_pull),
        .scl_in(scl_bus), .sda_in(sda_bus)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    task automatic issue(input logic [1:0] op, input logic [7:0] b, input logic ack);
        int n = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd = op; wr_byte = b; rd_ack = ack;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
        chk(done, "R10 done seen", int'(done), 1);
        r_st = status; r_rb = rd_byte; r_rec = recover_req;
        @(negedge clk);
        chk(!done, "R10 done one cycle", int'(done), 0);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !bus_open, "R1 reset idle", {busy, done, bus_open}, 0);
        chk(!scl_pull && !sda_pull, "R1 reset lines released", {scl_pull, sda_pull}, 0);
    endtask

    task automatic t_start(input int hp);
        int h0;
        half_period = 12'(hp);
        slv_mode = 0;
        h0 = hold_cnt;
        issue(2'd0, 8'h00, 1'b0);
        chk(r_st == 2'd0, "R2 start status", r_st, 0);
        chk(bus_open, "R2 bus_open set", int'(bus_open), 1);
        chk(hold_cnt - h0 == hp + 1, "R11 START hold length", hold_cnt - h0, hp + 1);
        chk(scl_pull && !sda_pull, "R1 open idle lines", {scl_pull, sda_pull}, 2);
    endtask

    task automatic t_write(input logic [7:0] b, input logic ack, input string tag);
        slv_mode = 1; slv_ack = ack; base = falls;
        issue(2'd2, b, 1'b0);
        chk(cap == b, {tag, " wire bits MSB first"}, cap, b);
        chk(r_st == (ack ? 2'd0 : 2'd1), {tag, " ack status"}, r_st, ack ? 0 : 1);
        slv_mode = 0;
    endtask

    task automatic t_read(input logic [7:0] b, input logic ack);
        slv_mode = 2; slv_tx = b; base = falls;
        issue(2'd3, 8'h00, ack);
        chk(r_rb == b, "R7 read byte", r_rb, b);
        chk(cap_ack == !ack, "R7 ack bit on wire", int'(cap_ack), int'(!ack));
        chk(r_st == 2'd0, "R7 read status", r_st, 0);
        slv_mode = 0;
    endtask

    task automatic t_rstart();
        int r0 = rel_cnt;
        issue(2'd0, 8'h00, 1'b0);
        chk(r_st == 2'd0 && bus_open, "R4 repeated start ok", r_st, 0);
        chk(rel_cnt - r0 > int'(half_period) + 1, "R4 lines released first", rel_cnt - r0,
            int'(half_period) + 2);
    endtask

    task automatic t_stop();
        issue(2'd1, 8'h00, 1'b0);
        chk(r_st == 2'd0, "R9 stop status", r_st, 0);
        chk(!bus_open && !scl_pull && !sda_pull, "R9 stop released",
            {bus_open, scl_pull, sda_pull}, 0);
    endtask

    task automatic t_stretch();
        slv_mode = 1; slv_ack = 1'b1; base = falls; slv_scl_hold = 1'b1;
        fork
            issue(2'd2, 8'hC3, 1'b0);
            begin repeat (60) @(negedge clk); slv_scl_hold = 1'b0; end
        join
        chk(r_st == 2'd0, "R8 short stretch ok", r_st, 0);
        chk(cap == 8'hC3, "R8 bits after stretch", cap, 8'hC3);
        slv_mode = 0;
    endtask

    task automatic t_ignore();
        int n = 0;
        slv_mode = 1; slv_ack = 1'b1; base = falls;
        @(negedge clk);
        cmd_valid = 1'b1; cmd = 2'd2; wr_byte = 8'h11;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (5) @(negedge clk);
        cmd_valid = 1'b1; cmd = 2'd1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
        chk(done && status == 2'd0, "R10 write completes", status, 0);
        repeat (20) @(negedge clk);
        chk(bus_open && !busy, "R10 stop ignored while busy", {bus_open, busy}, 2);
        slv_mode = 0;
    endtask

    task automatic t_arb_write();
        slv_mode = 3; base = falls;
        issue(2'd2, 8'h80, 1'b0);
        chk(r_st == 2'd2, "R6 arbitration on write", r_st, 2);
        chk(r_rec, "R6 recover pulse", int'(r_rec), 1);
        chk(!bus_open && !scl_pull && !sda_pull, "R6 lines released",
            {bus_open, scl_pull, sda_pull}, 0);
        slv_mode = 0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_arb_start();
        slv_mode = 4;
        repeat (4) @(negedge clk);
        issue(2'd0, 8'h00, 1'b0);
        chk(r_st == 2'd2 && r_rec, "R3 start arbitration", r_st, 2);
        chk(!bus_open && !sda_pull, "R3 bus not opened", {bus_open, sda_pull}, 0);
        slv_mode = 0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_timeout();
        slv_scl_hold = 1'b1; base = falls;
        issue(2'd2, 8'hFF, 1'b0);
        chk(r_st == 2'd3, "R8 stretch timeout", r_st, 3);
        chk(!bus_open && !scl_pull && !sda_pull, "R8 timeout releases",
            {bus_open, scl_pull, sda_pull}, 0);
        slv_scl_hold = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_stop_arb();
        slv_mode = 4;
        issue(2'd1, 8'h00, 1'b0);
        chk(r_st == 2'd2 && r_rec, "R9 stop sees SDA low", r_st, 2);
        chk(!bus_open, "R9 stop closes", int'(bus_open), 0);
        slv_mode = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_start(3);
        t_write(8'hA5, 1'b1, "R5");
        t_write(8'h3C, 1'b0, "R5 nack");
        t_rstart();
        t_read(8'h96, 1'b1);
        t_read(8'h5A, 1'b0);
        t_stop();
        t_start(7);
        t_stretch();
        t_ignore();
        t_arb_write();
        t_arb_start();
        t_start(2);
        t_timeout();
        t_start(2);
        t_stop_arb();
        finish_run();
    end
endmodule